// File: doc/BRIEF.md
# Dual-Channel Simultaneous-Sampling Converter Core

This block is the digital side of a converter with two track/hold paths that sample at the same instant. A falling edge on the active-low conversion-start input freezes both sample values of the group chosen by a select bit. It then runs a conversion timer of a fixed number of system clock cycles, with a busy flag high the whole time. When the timer expires it moves both 14-bit results into an output register in one cycle. The analog converter is modelled by four sample-value inputs, two per group, which an external driver sets.

A host reads the two results over one 14-bit bus. It holds chip select low and gives successive low pulses on the read strobe. An internal pointer gives the first result on the first pulse and the second on the next. A third pulse wraps back to the first. The bus value is qualified by an output-enable that a pad-level tri-state buffer uses. Results are 14-bit two's complement codes and are passed through unchanged.

Top module: `dual_adc_core`

## Requirements
- R1: After reset busy is low, rd_oe is low, both stored results are zero and the read pointer selects the first result.
- R2: A 1-to-0 transition of conv_start_n sampled while busy is low starts a conversion, and busy is high from the following clock cycle. Holding conv_start_n low does not start a further conversion.
- R3: busy stays high for exactly CONV_CYCLES clock cycles per conversion.
- R4: During a conversion the output register keeps the previous results. Both new results appear together in the cycle busy returns low.
- R5: With grp_sel = 0 at the start edge the results are samp_a1 then samp_a2. With grp_sel = 1 they are samp_b1 then samp_b2. Changes to grp_sel or any sample input after the start edge do not alter the results.
- R6: A falling edge of conv_start_n while busy is high is ignored. Neither the busy length nor the results change.
- R7: rd_oe is high only while both cs_n and rd_n are low, and rd_data is all zeros whenever rd_oe is low.
- R8: Within one cs_n low period, the first rd_n low pulse returns the first result, the second pulse returns the second, and a third returns the first again.
- R9: Raising cs_n returns the read pointer to the first result.
- R10: Completion of a conversion returns the read pointer to the first result, even while cs_n stays low.
- R11: Codes are passed bit-exact. The most positive code 14'h1FFF and the most negative code 14'h2000 come back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start_n | input | 1 | Active-low conversion start; the falling edge triggers |
| grp_sel | input | 1 | Group select: 0 chooses group A, 1 chooses group B |
| samp_a1 | input | 14 | Sample value, group A input 1 |
| samp_a2 | input | 14 | Sample value, group A input 2 |
| samp_b1 | input | 14 | Sample value, group B input 1 |
| samp_b2 | input | 14 | Sample value, group B input 2 |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| busy | output | 1 | High while a conversion runs |
| rd_data | output | 14 | Result selected by the read pointer |
| rd_oe | output | 1 | Enable for the pad tri-state driver of rd_data |

## Verification
A timer count that is off by one shows as a busy pulse one cycle too long or too short. That is visible on the first conversion. A corrupted hold or result register shows on the first read pulse after the conversion ends. A stuck or misadvancing read pointer returns the wrong result on the second or third strobe of a chip-select window. A pointer that misses a reset returns the second result first, on the first read after cs_n rises or after a conversion completes. Each such fault surfaces within one conversion period plus three read pulses.

// File: rtl/dadc_pkg.sv
package dadc_pkg;
    parameter int unsigned SAMPLE_W = 14;
    parameter int unsigned NUM_RES  = 2;
    parameter int unsigned PTR_W    = (NUM_RES > 1) ? $clog2(NUM_RES) : 1;

    typedef logic [SAMPLE_W-1:0]              sample_t;
    typedef logic [NUM_RES-1:0][SAMPLE_W-1:0] res_vec_t;
    typedef logic [PTR_W-1:0]                 ptr_t;
endpackage

// File: rtl/dadc_conv_timer.sv
module dadc_conv_timer #(
    parameter int unsigned CONV_CYCLES = 52
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_start_n,
    output logic start_acc,
    output logic busy,
    output logic done
);
    localparam int unsigned CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

    typedef struct packed {
        logic             start_q;
        logic             busy_q;
        logic [CNT_W-1:0] cnt_q;
    } tmr_state_t;

    tmr_state_t st_q, st_d;
    logic       fall;

    always_comb begin
        st_d      = st_q;
        fall      = st_q.start_q & ~conv_start_n;
        start_acc = fall & ~st_q.busy_q;
        done      = st_q.busy_q && (st_q.cnt_q == '0);
        st_d.start_q = conv_start_n;
        if (start_acc) begin
            st_d.busy_q = 1'b1;
            st_d.cnt_q  = CNT_LOAD;
        end else if (st_q.busy_q) begin
            if (st_q.cnt_q == '0) begin
                st_d.busy_q = 1'b0;
            end else begin
                st_d.cnt_q = st_q.cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{start_q: 1'b1, busy_q: 1'b0, cnt_q: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy_q;

    // R2
    start_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.start_q && !conv_start_n && !st_q.busy_q) |=> st_q.busy_q);

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy_q && st_q.cnt_q != '0) |=> st_q.busy_q);

    // R3
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !st_q.busy_q);

    // R6
    restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy_q && st_q.cnt_q != '0 && fall)
        |=> (st_q.cnt_q == $past(st_q.cnt_q) - 1'b1));
endmodule

// File: rtl/dadc_sample_hold.sv
module dadc_sample_hold
    import dadc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     capture,
    input  logic     grp_sel,
    input  res_vec_t grp_a,
    input  res_vec_t grp_b,
    output res_vec_t held
);
    typedef struct packed {
        res_vec_t held_q;
    } hold_state_t;

    hold_state_t st_q, st_d;
    res_vec_t    pick;

    for (genvar g = 0; g < NUM_RES; g++) begin : g_path
        assign pick[g] = grp_sel ? grp_b[g] : grp_a[g];
    end

    always_comb begin
        st_d = st_q;
        if (capture) begin
            st_d.held_q = pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held = st_q.held_q;

    // R5
    hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(st_q.held_q));

    // R5
    hold_group_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !grp_sel) |=> (st_q.held_q == $past(grp_a)));

    // R5
    hold_group_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && grp_sel) |=> (st_q.held_q == $past(grp_b)));
endmodule

// File: rtl/dadc_result_reg.sv
module dadc_result_reg
    import dadc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     done,
    input  res_vec_t held,
    output res_vec_t res
);
    typedef struct packed {
        res_vec_t res_q;
    } res_state_t;

    res_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (done) begin
            st_d.res_q = held;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res = st_q.res_q;

    // R4
    res_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(st_q.res_q));

    // R4
    res_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (st_q.res_q == $past(held)));
endmodule

// File: rtl/dadc_read_seq.sv
module dadc_read_seq
    import dadc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_n,
    input  logic     rd_n,
    input  logic     done,
    input  res_vec_t res,
    output sample_t  rd_data,
    output logic     rd_oe
);
    localparam ptr_t PTR_LAST = PTR_W'(NUM_RES - 1);

    typedef struct packed {
        logic rd_q;
        ptr_t ptr_q;
    } rd_state_t;

    rd_state_t st_q, st_d;
    logic      rd_rise;

    always_comb begin
        st_d      = st_q;
        rd_rise   = ~st_q.rd_q & rd_n & ~cs_n;
        st_d.rd_q = rd_n;
        if (cs_n || done) begin
            st_d.ptr_q = '0;
        end else if (rd_rise) begin
            st_d.ptr_q = (st_q.ptr_q == PTR_LAST) ? '0 : st_q.ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rd_q: 1'b1, ptr_q: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_oe   = ~cs_n & ~rd_n;
        rd_data = rd_oe ? res[st_q.ptr_q] : '0;
    end

    // R9
    ptr_cs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (st_q.ptr_q == '0));

    // R10
    ptr_done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (st_q.ptr_q == '0));

    // R8
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rise && !done && st_q.ptr_q == PTR_LAST) |=> (st_q.ptr_q == '0));

    // R8
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rise && !done && st_q.ptr_q != PTR_LAST)
        |=> (st_q.ptr_q == $past(st_q.ptr_q) + 1'b1));
endmodule

// File: rtl/dual_adc_core.sv
module dual_adc_core
    import dadc_pkg::*;
#(
    parameter int unsigned CONV_CYCLES = 52
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_start_n,
    input  logic                grp_sel,
    input  logic [SAMPLE_W-1:0] samp_a1,
    input  logic [SAMPLE_W-1:0] samp_a2,
    input  logic [SAMPLE_W-1:0] samp_b1,
    input  logic [SAMPLE_W-1:0] samp_b2,
    input  logic                cs_n,
    input  logic                rd_n,
    output logic                busy,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic                rd_oe
);
    res_vec_t grp_a, grp_b, held, res;
    logic     start_acc, done;

    assign grp_a = {samp_a2, samp_a1};
    assign grp_b = {samp_b2, samp_b1};

    dadc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_start_n (conv_start_n),
        .start_acc    (start_acc),
        .busy         (busy),
        .done         (done)
    );

    dadc_sample_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (start_acc),
        .grp_sel (grp_sel),
        .grp_a   (grp_a),
        .grp_b   (grp_b),
        .held    (held)
    );

    dadc_result_reg u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (done),
        .held  (held),
        .res   (res)
    );

    dadc_read_seq u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .done    (done),
        .res     (res),
        .rd_data (rd_data),
        .rd_oe   (rd_oe)
    );
endmodule

// File: tb/dual_adc_core_tb.sv
`timescale 1ns/1ps
module dual_adc_core_tb;
    localparam int CLK_P = 100;
    localparam int CONV  = 52;

    typedef struct packed {
        logic        sel;
        logic [13:0] a1, a2, b1, b2;
        logic [13:0] e1, e2;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{1'b0, 14'h0123, 14'h0456, 14'h0789, 14'h0ABC, 14'h0123, 14'h0456},
        '{1'b1, 14'h0123, 14'h0456, 14'h0789, 14'h0ABC, 14'h0789, 14'h0ABC},
        '{1'b0, 14'h1FFF, 14'h2000, 14'h0001, 14'h3FFF, 14'h1FFF, 14'h2000},
        '{1'b1, 14'h0000, 14'h0000, 14'h2000, 14'h1FFF, 14'h2000, 14'h1FFF},
        '{1'b0, 14'h3FFF, 14'h0001, 14'h1555, 14'h2AAA, 14'h3FFF, 14'h0001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_start_n = 1'b1;
    logic        grp_sel = 1'b0;
    logic [13:0] samp_a1 = '0, samp_a2 = '0, samp_b1 = '0, samp_b2 = '0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        busy;
    logic [13:0] rd_data;
    logic        rd_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    dual_adc_core #(.CONV_CYCLES(CONV)) u_dut (
        .clk(clk), .rst_n(rst_n), .conv_start_n(conv_start_n), .grp_sel(grp_sel),
        .samp_a1(samp_a1), .samp_a2(samp_a2), .samp_b1(samp_b1), .samp_b2(samp_b2),
        .cs_n(cs_n), .rd_n(rd_n), .busy(busy), .rd_data(rd_data), .rd_oe(rd_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_samples(input logic [13:0] a1, a2, b1, b2);
        samp_a1 = a1; samp_a2 = a2; samp_b1 = b1; samp_b2 = b2;
    endtask

    // One read pulse; returns the bus value seen while the strobe is low.
    task automatic read_pulse(output logic [13:0] val);
        @(negedge clk);
        rd_n = 1'b0;
        #1;
        val = rd_data;
        @(negedge clk);
        rd_n = 1'b1;
    endtask

    // Start a conversion and count busy cycles; optional restart and input churn.
    task automatic convert(input logic sel, input bit churn);
        int cnt;
        @(negedge clk);
        grp_sel = sel;
        conv_start_n = 1'b0;
        @(negedge clk);
        conv_start_n = 1'b1;
        check("R2 busy after start edge", busy, 1);
        cnt = 0;
        while (busy && cnt < 1000) begin
            cnt++;
            if (churn && cnt == 1) begin
                grp_sel = ~sel;
                set_samples(14'h3333, 14'h3444, 14'h3555, 14'h3666);
            end
            if (churn && cnt == 4) conv_start_n = 1'b0;
            if (churn && cnt == 5) conv_start_n = 1'b1;
            @(negedge clk);
        end
        check(churn ? "R6 busy length with restart" : "R3 busy length", cnt, CONV);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [13:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 rd_oe", rd_oe, 0);
        cs_n = 1'b0;
        read_pulse(v); check("R1 first result zero", v, 0);
        read_pulse(v); check("R1 second result zero", v, 0);
        @(negedge clk); cs_n = 1'b1;

        // Table walk: R5 group select, R8 read order and wrap, R11 codes
        foreach (VECS[i]) begin
            set_samples(VECS[i].a1, VECS[i].a2, VECS[i].b1, VECS[i].b2);
            convert(VECS[i].sel, 1'b0);
            @(negedge clk); cs_n = 1'b0;
            read_pulse(v); check("R5/R11 first read", v, VECS[i].e1);
            read_pulse(v); check("R8 second read", v, VECS[i].e2);
            read_pulse(v); check("R8 third read wraps", v, VECS[i].e1);
            @(negedge clk); cs_n = 1'b1;
        end

        // R4 old results during busy; R10 pointer cleared at completion
        set_samples(14'h0AAA, 14'h0BBB, 14'h0CCC, 14'h0DDD);
        @(negedge clk); grp_sel = 1'b0; conv_start_n = 1'b0;
        @(negedge clk); conv_start_n = 1'b1;
        cs_n = 1'b0;
        read_pulse(v); check("R4 old result during busy", v, 14'h3FFF);
        while (busy) @(negedge clk);
        read_pulse(v); check("R10 pointer reset at completion", v, 14'h0AAA);
        read_pulse(v); check("R4 new second result", v, 14'h0BBB);
        @(negedge clk); cs_n = 1'b1;

        // R5 inputs frozen at start edge; R6 restart while busy ignored
        set_samples(14'h0111, 14'h0222, 14'h0999, 14'h0888);
        convert(1'b0, 1'b1);
        @(negedge clk); cs_n = 1'b0;
        read_pulse(v); check("R5 frozen first", v, 14'h0111);
        read_pulse(v); check("R6 result kept second", v, 14'h0222);

        // R9 pointer back to first when cs_n rises
        read_pulse(v); check("R9 setup read", v, 14'h0111);
        read_pulse(v); check("R9 setup read second", v, 14'h0222);
        read_pulse(v);
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk); cs_n = 1'b0;
        read_pulse(v); check("R9 first after cs_n rise", v, 14'h0111);

        // R7 bus qualification
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b1; #1;
        check("R7 oe with rd_n high", rd_oe, 0);
        check("R7 data with rd_n high", rd_data, 0);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; #1;
        check("R7 oe with cs_n high", rd_oe, 0);
        check("R7 data with cs_n high", rd_data, 0);
        @(negedge clk); cs_n = 1'b0; #1;
        check("R7 oe with both low", rd_oe, 1);
        @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;

        // R2 held-low start triggers once only
        @(negedge clk); conv_start_n = 1'b0;
        @(negedge clk);
        check("R2 busy on held-low start", busy, 1);
        begin
            int cnt = 0;
            while (busy && cnt < 1000) begin cnt++; @(negedge clk); end
            check("R3 busy length held-low", cnt, CONV);
        end
        repeat (10) @(negedge clk);
        check("R2 no retrigger while held low", busy, 0);
        conv_start_n = 1'b1;
        repeat (3) @(negedge clk);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule